// File: doc/BRIEF.md
# Waveform Playback Sequencer

This block turns a waveform stored in external sample memory into a stream of words for a parallel digital-to-analog converter. Once started, it reads one sample per sample period from the asynchronous SRAM and places the word on the converter's data lines. A one-cycle strobe follows while those lines are steady. After the last sample of the programmed waveform it returns to address 0, so the waveform repeats for as long as playback stays enabled.

The sample period is a whole number of 50 MHz clock cycles, taken from a wide divider input. The fastest rate is limited by the three-cycle SRAM read, not by the clock. The divider is wide enough to give periods of several minutes. Period and waveform length are captured when playback starts. Dropping the run input stops playback at once and leaves the last sample on the converter.

Top module: `wps_sequencer`

## Requirements
- R1: While reset is asserted and after its release, before playback starts, `dac_data_o` is 0 and `dac_strobe_o`, `sram_oe_o` and `sram_addr_o` are 0.
- R2: `dac_strobe_o` is high for exactly one cycle per sample. `dac_data_o` holds the same value in the cycle before the strobe and during the strobe.
- R3: Sample k of a run is the SRAM word at address k modulo L, where L is the captured length (L = 1 when the length is 0 or 1). Each sample is read from the address shown on `sram_addr_o` while `sram_oe_o` is high.
- R4: For a period value P of 3 or more, consecutive strobes are exactly P clock cycles apart.
- R5: A period value of 0, 1 or 2 gives strobes exactly 3 cycles apart.
- R6: A length value of 0 or 1 repeats the word at address 0 on every strobe.
- R7: Every SRAM read holds `sram_oe_o` high for exactly 3 consecutive cycles when the period exceeds 3.
- R8: If `run_i` is first sampled high at clock edge s, the read of address 0 starts at edge s and the first strobe is high after edge s+4.
- R9: Once `run_i` is sampled low, `dac_data_o` does not change and `sram_oe_o` is low. At most one strobe follows, in the next cycle, for a sample already on the lines.
- R10: `period_i` and `length_i` are captured when playback starts. Changing them during playback does not alter the spacing or the wrap point.
- R11: Restarting after a stop begins again at address 0.
- R12: `period_i` is 34 bits wide, so periods up to 2^34-1 cycles are supported. A period of 2^33 produces no second strobe within hundreds of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Playback enable; a rising level starts playback from address 0 |
| period_i | input | 34 | Sample period in clock cycles (values below 3 act as 3) |
| length_i | input | 20 | Waveform length in samples (0 or 1 means one sample) |
| sram_addr_o | output | 19 | SRAM read address |
| sram_oe_o | output | 1 | SRAM output enable, high during a read |
| sram_data_i | input | 12 | SRAM read data |
| dac_data_o | output | 12 | Converter data lines |
| dac_strobe_o | output | 1 | Converter load strobe, one cycle |

## Verification
The bench aims at the wrap point. A design with an off-by-one there would play one sample too many or too few, which shows up in the sample values. It also uses period values at and below the read time. A design that did not clamp them would overlap reads or strobe every cycle, and the spacing check catches that. Inputs are changed mid-run to show that a design failing to capture them would shift its spacing or its wrap point. The stop and restart tests look for a design that keeps updating the converter after stop, or that resumes mid-waveform instead of at address 0.

// File: rtl/wps_pkg.sv
package wps_pkg;
    localparam int DEF_ADDR_W   = 19;
    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_DIV_W    = 34;
    localparam int DEF_READ_CYC = 3;

    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_BUSY = 1'b1
    } fetch_mode_e;
endpackage

// File: rtl/wps_rate_timer.sv
module wps_rate_timer #(
    parameter int DIV_W   = 34,
    parameter int MIN_PER = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] period_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_PER);

    typedef struct packed {
        logic             active;
        logic [DIV_W-1:0] per;
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [DIV_W-1:0] per_eff;

    always_comb begin
        per_eff = (period_i < MIN_V) ? MIN_V : period_i;
        st_d    = st_q;
        if (stop_i) begin
            st_d.active = 1'b0;
        end else if (start_i) begin
            st_d.active = 1'b1;
            st_d.per    = per_eff;
            st_d.cnt    = per_eff - 1'b1;
        end else if (st_q.active) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.per - 1'b1;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.active && (st_q.cnt == '0) && !stop_i;
endmodule

// File: rtl/wps_addr_gen.sv
module wps_addr_gen #(
    parameter int ADDR_W = 19
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              advance_i,
    input  logic [ADDR_W:0]   len_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W:0]   len;
        logic [ADDR_W-1:0] cur;
    } ag_t;

    ag_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W:0]   n);
        logic [ADDR_W:0] inc;
        inc = {1'b0, a} + 1'b1;
        return (inc >= n) ? '0 : inc[ADDR_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.len = len_i;
            st_d.cur = wrap_next('0, len_i);
        end else if (advance_i) begin
            st_d.cur = wrap_next(st_q.cur, st_q.len);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign addr_o = st_q.cur;
endmodule

// File: rtl/wps_fetch.sv
module wps_fetch
    import wps_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int READ_CYC = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_oe_o,
    output logic              cap_o
);
    localparam int             PH_W = (READ_CYC > 1) ? $clog2(READ_CYC) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(READ_CYC - 1);

    typedef struct packed {
        fetch_mode_e       mode;
        logic [PH_W-1:0]   ph;
        logic [ADDR_W-1:0] addr;
    } fx_t;

    fx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d.mode = FETCH_IDLE;
        end else if (go_i) begin
            st_d.mode = FETCH_BUSY;
            st_d.ph   = '0;
            st_d.addr = addr_i;
        end else if (st_q.mode == FETCH_BUSY) begin
            if (st_q.ph == LAST) st_d.mode = FETCH_IDLE;
            else                 st_d.ph   = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{mode: FETCH_IDLE, ph: '0, addr: '0};
        else         st_q <= st_d;
    end

    assign sram_addr_o = st_q.addr;
    assign sram_oe_o   = (st_q.mode == FETCH_BUSY);
    assign cap_o       = (st_q.mode == FETCH_BUSY) && (st_q.ph == LAST) && !abort_i;
endmodule

// File: rtl/wps_sequencer.sv
module wps_sequencer
    import wps_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int DIV_W    = DEF_DIV_W,
    parameter int READ_CYC = DEF_READ_CYC
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic [DIV_W-1:0]    period_i,
    input  logic [ADDR_W:0]     length_i,
    output logic [ADDR_W-1:0]   sram_addr_o,
    output logic                sram_oe_o,
    input  logic [SAMPLE_W-1:0] sram_data_i,
    output logic [SAMPLE_W-1:0] dac_data_o,
    output logic                dac_strobe_o
);
    typedef struct packed {
        logic                running;
        logic [SAMPLE_W-1:0] dac;
        logic                upd;
        logic                strobe;
    } seq_t;

    seq_t              st_d, st_q;
    logic              start, stop, tick, go, cap;
    logic [ADDR_W-1:0] next_addr, fetch_addr;

    assign stop       = !run_i;
    assign start      = run_i && !st_q.running;
    assign go         = start || tick;
    assign fetch_addr = start ? '0 : next_addr;

    wps_rate_timer #(.DIV_W(DIV_W), .MIN_PER(READ_CYC)) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .stop_i   (stop),
        .period_i (period_i),
        .tick_o   (tick)
    );

    wps_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .advance_i (tick),
        .len_i     (length_i),
        .addr_o    (next_addr)
    );

    wps_fetch #(.ADDR_W(ADDR_W), .READ_CYC(READ_CYC)) i_fetch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .abort_i     (stop),
        .addr_i      (fetch_addr),
        .sram_addr_o (sram_addr_o),
        .sram_oe_o   (sram_oe_o),
        .cap_o       (cap)
    );

    always_comb begin
        st_d         = st_q;
        st_d.running = run_i;
        st_d.upd     = cap;
        st_d.strobe  = st_q.upd;
        if (cap) st_d.dac = sram_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dac_data_o   = st_q.dac;
    assign dac_strobe_o = st_q.strobe;
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int ADDR_W   = 19,
    parameter int SAMPLE_W = 12
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                run_i,
    input logic [ADDR_W-1:0]   sram_addr_o,
    input logic                sram_oe_o,
    input logic [SAMPLE_W-1:0] dac_data_o,
    input logic                dac_strobe_o
);
    // R2
    strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_strobe_o |=> !dac_strobe_o);

    // R2
    strobe_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_strobe_o |-> $stable(dac_data_o));

    // R7
    read_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_strobe_o |-> ($past(sram_oe_o, 2) && $past(sram_oe_o, 3) && $past(sram_oe_o, 4)));

    // R9
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> $stable(dac_data_o));

    // R9
    stop_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !sram_oe_o);

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!dac_strobe_o && !sram_oe_o && dac_data_o == '0 && sram_addr_o == '0));
endmodule

bind wps_sequencer wps_checker #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .sram_addr_o  (sram_addr_o),
    .sram_oe_o    (sram_oe_o),
    .dac_data_o   (dac_data_o),
    .dac_strobe_o (dac_strobe_o)
);

// File: tb/test_wps_sequencer.sv
module test_wps_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [33:0] period = 34'd5;
    logic [19:0] length = 20'd4;
    logic [18:0] sram_addr;
    logic        sram_oe;
    logic [11:0] sram_data;
    logic [11:0] dac_data;
    logic        dac_strobe;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     n_st = 0;
    longint st_cyc [64];
    logic [11:0] st_val [64];
    int     oe_len = 0;
    int     oe_runs = 0;
    int     oe_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [11:0] pat(input logic [18:0] a);
        return (a[11:0] * 12'd37 + 12'd5) ^ {5'd0, a[18:12]};
    endfunction

    assign sram_data = sram_oe ? pat(sram_addr) : 12'hBAD;

    wps_sequencer i_wps_sequencer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .run_i        (run),
        .period_i     (period),
        .length_i     (length),
        .sram_addr_o  (sram_addr),
        .sram_oe_o    (sram_oe),
        .sram_data_i  (sram_data),
        .dac_data_o   (dac_data),
        .dac_strobe_o (dac_strobe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (dac_strobe) begin
            if (n_st < 64) begin
                st_cyc[n_st] = cyc;
                st_val[n_st] = dac_data;
            end
            n_st = n_st + 1;
        end
        if (sram_oe) begin
            oe_len = oe_len + 1;
        end else if (oe_len != 0) begin
            oe_runs = oe_runs + 1;
            if (oe_len != 3) oe_bad = oe_bad + 1;
            oe_len = 0;
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic start_run(input logic [33:0] p, input logic [19:0] l, output longint s);
        step();
        period = p;
        length = l;
        run    = 1'b1;
        n_st   = 0;
        s      = cyc + 1;
    endtask

    task automatic stop_run();
        step();
        run = 1'b0;
        repeat (3) step();
    endtask

    task automatic wait_strobes(input int k);
        for (int g = 0; g < 20000 && n_st < k; g++) step();
    endtask

    task automatic verify_seq(input string req, input int k, input longint s,
                              input longint p, input int l);
        for (int i = 0; i < k; i++) begin
            chk(st_cyc[i] == s + 4 + i * p, {req, " strobe cycle"}, st_cyc[i], s + 4 + i * p);
            chk(st_val[i] == pat(19'(i % l)), {req, " sample value"}, st_val[i], pat(19'(i % l)));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        // R1: outputs idle during reset
        chk(dac_data == 0 && !dac_strobe && !sram_oe && sram_addr == 0, "R1 in reset",
            {dac_data, dac_strobe, sram_oe}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        chk(dac_data == 0 && !dac_strobe && !sram_oe, "R1 after reset",
            {dac_data, dac_strobe, sram_oe}, 0);
    endtask

    task automatic t_basic();
        longint s;
        start_run(34'd5, 20'd4, s);
        wait_strobes(6);
        chk(n_st >= 6, "R3 strobe count", n_st, 6);
        // R8: first strobe 4 edges after start; R3 wrap order; R4 spacing
        chk(st_cyc[0] == s + 4, "R8 first strobe latency", st_cyc[0], s + 4);
        verify_seq("R3 R4", 6, s, 5, 4);
        stop_run();
    endtask

    task automatic t_clamp(input logic [33:0] p);
        longint s;
        start_run(p, 20'd3, s);
        wait_strobes(5);
        // R5: short periods behave as 3
        verify_seq("R5", 5, s, 3, 3);
        stop_run();
    endtask

    task automatic t_single(input logic [19:0] l);
        longint s;
        start_run(34'd4, l, s);
        wait_strobes(4);
        // R6: one-sample waveform
        verify_seq("R6", 4, s, 4, 1);
        stop_run();
    endtask

    task automatic t_capture();
        longint s;
        start_run(34'd4, 20'd3, s);
        repeat (2) step();
        period = 34'd9;
        length = 20'd7;
        wait_strobes(7);
        // R10: inputs changed mid-run are ignored
        verify_seq("R10", 7, s, 4, 3);
        stop_run();
    endtask

    task automatic t_stop_restart();
        longint s;
        logic [11:0] held;
        start_run(34'd6, 20'd5, s);
        wait_strobes(3);
        step();
        run = 1'b0;
        repeat (2) step();
        held = dac_data;
        n_st = 0;
        repeat (60) step();
        // R9: no strobes, data held, reads stopped
        chk(n_st == 0, "R9 strobes after stop", n_st, 0);
        chk(dac_data == held, "R9 data held", dac_data, held);
        chk(!sram_oe, "R9 oe low", sram_oe, 0);
        start_run(34'd6, 20'd5, s);
        wait_strobes(2);
        // R11: restart from address 0
        chk(st_val[0] == pat(19'd0), "R11 restart sample", st_val[0], pat(19'd0));
        verify_seq("R11", 2, s, 6, 5);
        stop_run();
    endtask

    task automatic t_read_window();
        longint s;
        oe_runs = 0;
        oe_bad  = 0;
        start_run(34'd6, 20'd8, s);
        wait_strobes(5);
        // R7: each read keeps oe for 3 cycles
        chk(oe_runs >= 4, "R7 read count", oe_runs, 4);
        chk(oe_bad == 0, "R7 read length", oe_bad, 0);
        stop_run();
    endtask

    task automatic t_slow();
        longint s;
        start_run(34'h2_0000_0000, 20'd4, s);
        repeat (600) step();
        // R12: huge period, one strobe only
        chk(n_st == 1, "R12 strobes in window", n_st, 1);
        chk(st_cyc[0] == s + 4 && st_val[0] == pat(19'd0), "R12 first sample",
            st_val[0], pat(19'd0));
        stop_run();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_clamp(34'd0);
        t_clamp(34'd2);
        t_clamp(34'd3);
        t_single(20'd0);
        t_single(20'd1);
        t_capture();
        t_stop_restart();
        t_read_window();
        t_slow();
        report();
        $finish;
    end
endmodule